// File: doc/BRIEF.md
# Configuration Port Unlock Controller

This block is the configuration-space front end of an I/O controller. The host reaches it through two byte-wide I/O addresses: an index port and a data port one address above it. A strap input picks the index port address, 0x2E or 0x4E. Until the host writes a four-byte key to the index port, every configuration register is hidden. Data-port writes have no effect and reads return 0xFF.

Once unlocked, a byte written to the index port picks a configuration register, and the data port reads or writes that register. The block holds a read-only 16-bit chip identity and one global flash-control byte. It also has a logical-device select register, and that select opens a bank with the two bytes of the flash controller's I/O base. The flash-control fields and the I/O base drive output pins for the flash decoder. That decoder lies outside this block. Writing a fixed value to a fixed register locks the port again.

Host reads are registered. The read data appears, with a valid pulse, in the cycle after the read strobe. It shows the state as it stood before any write sampled on the same clock edge.

Top module: `cfg_unlock_top`

## Requirements
- R1: After reset the port is locked, the key matcher is at its first step, the logical-device select is 0, the flash I/O base is 0x0000, and the flash-control byte equals parameter CTL_RST.
- R2: Four index-port writes 0x87, 0x01, 0x55 and then a final byte unlock the port. `cfgUnlocked` rises on the clock edge that samples the final byte, and not before.
- R3: The final key byte is 0x55 when `strapAlt`=0 (index port 0x2E, data port 0x2F). It is 0xAA when `strapAlt`=1 (index port 0x4E, data port 0x4F). The other value does not unlock the port, and the unselected port pair is ignored.
- R4: A wrong byte during the key sends the matcher back to its first step. A wrong byte that equals 0x87 counts as the first key byte, so the match continues at step two.
- R5: While locked, data-port writes change nothing, and reads of either port return 0xFF.
- R6: While unlocked, an index-port write selects the register, and an index-port read returns the selected index.
- R7: While unlocked, writing 0x02 to register 0x02 locks the port. Any other value written there leaves the port unlocked.
- R8: Register 0x20 reads the high byte of parameter CHIP_ID and register 0x21 reads the low byte. Writes to either register are ignored.
- R9: Register 0x07 holds the logical-device select. Registers 0x64 (high byte) and 0x65 (low byte) form `flashIoBase`. They exist only while the select equals FLASH_LDN (default 7). With any other select they read 0xFF and ignore writes.
- R10: Register 0x24 is global, whatever the select. Bit 0 drives `flashSuspend`, bits 3:1 drive `flashSegEn[2:0]`, bit 4 drives `flashHostWrEn` and bit 5 drives `flashPinAlt`.
- R11: A read of either port gives `ioRdValid` for one cycle, in the cycle after `ioRd`. `ioRdata` shows the state from before any write sampled on the same edge.
- R12: Reads and writes to any other address produce no `ioRdValid` and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapAlt | input | 1 | Port-pair strap: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| ioWr | input | 1 | Host I/O write strobe |
| ioRd | input | 1 | Host I/O read strobe |
| ioAddr | input | ADDR_W | Host I/O address |
| ioWdata | input | 8 | Host write byte |
| ioRdata | output | 8 | Read byte, valid with ioRdValid |
| ioRdValid | output | 1 | One-cycle read-data valid |
| cfgUnlocked | output | 1 | Configuration space is open |
| ldnSel | output | 8 | Current logical-device select |
| flashSuspend | output | 1 | Flash-control bit 0 |
| flashSegEn | output | 3 | Flash segment enables (bits 3:1) |
| flashHostWrEn | output | 1 | Host writes to flash enabled (bit 4) |
| flashPinAlt | output | 1 | Alternate flash pin assignment (bit 5) |
| flashIoBase | output | 16 | Flash controller I/O base from the device bank |

## Verification
A read and a write can fall in the same cycle, and the bench provokes this by raising both strobes on the data port while register 0x24 is selected. The read must return the byte from before the write, and a later plain read must return the new byte. The scoreboard judges both results from its queue of expected bytes. Keying itself is checked across the cycle where the final byte lands: the bench samples `cfgUnlocked` low after the third byte and high after the fourth.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;

  localparam logic [15:0] IDX_PORT_PRI = 16'h002E;
  localparam logic [15:0] IDX_PORT_ALT = 16'h004E;

  localparam logic [7:0] KEY_B0       = 8'h87;
  localparam logic [7:0] KEY_B1       = 8'h01;
  localparam logic [7:0] KEY_B2       = 8'h55;
  localparam logic [7:0] KEY_LAST_PRI = 8'h55;
  localparam logic [7:0] KEY_LAST_ALT = 8'hAA;

  localparam logic [7:0] REG_LOCK    = 8'h02;
  localparam logic [7:0] LOCK_VAL    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_FCTL    = 8'h24;
  localparam logic [7:0] REG_BASE_HI = 8'h64;
  localparam logic [7:0] REG_BASE_LO = 8'h65;

  typedef enum logic [2:0] {
    RS_NONE, RS_IDX, RS_LDN, RS_IDH, RS_IDL, RS_FCTL, RS_BHI, RS_BLO
  } rdSel_e;

  typedef struct packed {
    logic   wrLdn;
    logic   wrFctl;
    logic   wrBaseHi;
    logic   wrBaseLo;
    logic   rdEn;
    rdSel_e rdSel;
  } cfgStrb_t;

endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_unlock_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  FLASH_LDN = 8'd7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapAlt,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWdata,
  input  logic [7:0]        ldnCur,
  output cfgStrb_t          strb,
  output logic [7:0]        idxCur,
  output logic              unlocked
);

  logic [ADDR_W-1:0] idxAddr;
  logic [ADDR_W-1:0] dataAddr;
  logic              idxHit;
  logic              dataHit;
  logic [1:0]        keyStep;
  logic [7:0]        keyByte;
  logic              relock;
  logic              regWr;
  logic              bankOk;

  assign idxAddr  = strapAlt ? ADDR_W'(IDX_PORT_ALT) : ADDR_W'(IDX_PORT_PRI);
  assign dataAddr = idxAddr + ADDR_W'(1);
  assign idxHit   = (ioAddr == idxAddr);
  assign dataHit  = (ioAddr == dataAddr);

  always_comb begin
    case (keyStep)
      2'd0:    keyByte = KEY_B0;
      2'd1:    keyByte = KEY_B1;
      2'd2:    keyByte = KEY_B2;
      default: keyByte = strapAlt ? KEY_LAST_ALT : KEY_LAST_PRI;
    endcase
  end

  assign regWr  = unlocked && ioWr && dataHit;
  assign relock = regWr && (idxCur == REG_LOCK) && (ioWdata == LOCK_VAL);
  assign bankOk = (ldnCur == FLASH_LDN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyStep  <= 2'd0;
      unlocked <= 1'b0;
      idxCur   <= 8'h00;
    end else begin
      if (ioWr && idxHit) begin
        if (unlocked) begin
          idxCur <= ioWdata;
        end else if (ioWdata == keyByte) begin
          if (keyStep == 2'd3) begin
            unlocked <= 1'b1;
            keyStep  <= 2'd0;
          end else begin
            keyStep <= keyStep + 2'd1;
          end
        end else if (ioWdata == KEY_B0) begin
          keyStep <= 2'd1;
        end else begin
          keyStep <= 2'd0;
        end
      end
      if (relock) unlocked <= 1'b0;
    end
  end

  always_comb begin
    strb          = '0;
    strb.wrLdn    = regWr && (idxCur == REG_LDN);
    strb.wrFctl   = regWr && (idxCur == REG_FCTL);
    strb.wrBaseHi = regWr && bankOk && (idxCur == REG_BASE_HI);
    strb.wrBaseLo = regWr && bankOk && (idxCur == REG_BASE_LO);
    strb.rdEn     = ioRd && (idxHit || dataHit);
    strb.rdSel    = RS_NONE;
    if (unlocked) begin
      if (idxHit) begin
        strb.rdSel = RS_IDX;
      end else begin
        case (idxCur)
          REG_LDN:     strb.rdSel = RS_LDN;
          REG_ID_HI:   strb.rdSel = RS_IDH;
          REG_ID_LO:   strb.rdSel = RS_IDL;
          REG_FCTL:    strb.rdSel = RS_FCTL;
          REG_BASE_HI: strb.rdSel = bankOk ? RS_BHI : RS_NONE;
          REG_BASE_LO: strb.rdSel = bankOk ? RS_BLO : RS_NONE;
          default:     strb.rdSel = RS_NONE;
        endcase
      end
    end
  end

  // R5: no register write strobe while locked
  p_locked_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> !(strb.wrLdn || strb.wrFctl || strb.wrBaseHi || strb.wrBaseLo));

  // R2: the port opens only from the last key step
  p_unlock_from_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlocked) |-> ($past(keyStep) == 2'd3));

  // R2: matcher stays idle while open
  p_matcher_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    unlocked |-> (keyStep == 2'd0));

  // R7: relock write closes the port
  p_relock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (unlocked && ioWr && dataHit && idxCur == REG_LOCK && ioWdata == LOCK_VAL)
      |=> !unlocked);

  // R9: bank registers written only with the flash device selected
  p_bank_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrBaseHi || strb.wrBaseLo) |-> (ldnCur == FLASH_LDN));

endmodule

// File: rtl/cfg_data.sv
module cfg_data
  import cfg_unlock_pkg::*;
#(
  parameter logic [15:0] CHIP_ID = 16'h8716,
  parameter logic [7:0]  CTL_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  cfgStrb_t   strb,
  input  logic [7:0] wdata,
  input  logic [7:0] idxCur,
  output logic [7:0] ldnReg,
  output logic [7:0] fctlReg,
  output logic [15:0] baseReg,
  output logic [7:0] rdData,
  output logic       rdValid
);

  logic [7:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldnReg  <= 8'h00;
      fctlReg <= CTL_RST;
      baseReg <= 16'h0000;
    end else begin
      if (strb.wrLdn)    ldnReg       <= wdata;
      if (strb.wrFctl)   fctlReg      <= wdata;
      if (strb.wrBaseHi) baseReg[15:8] <= wdata;
      if (strb.wrBaseLo) baseReg[7:0]  <= wdata;
    end
  end

  always_comb begin
    case (strb.rdSel)
      RS_IDX:  rdMux = idxCur;
      RS_LDN:  rdMux = ldnReg;
      RS_IDH:  rdMux = CHIP_ID[15:8];
      RS_IDL:  rdMux = CHIP_ID[7:0];
      RS_FCTL: rdMux = fctlReg;
      RS_BHI:  rdMux = baseReg[15:8];
      RS_BLO:  rdMux = baseReg[7:0];
      default: rdMux = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= 8'hFF;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= rdMux;
    end
  end

  // R10: flash-control byte moves only on its write strobe
  p_fctl_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFctl |=> $stable(fctlReg));

  // R11: valid follows a read request by one cycle
  p_rd_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.rdEn));

  // R9: base bytes move only on their strobes
  p_base_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrBaseHi || strb.wrBaseLo) |=> $stable(baseReg));

endmodule

// File: rtl/cfg_unlock_top.sv
module cfg_unlock_top
  import cfg_unlock_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] CHIP_ID   = 16'h8716,
  parameter logic [7:0]  CTL_RST   = 8'h00,
  parameter logic [7:0]  FLASH_LDN = 8'd7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapAlt,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWdata,
  output logic [7:0]        ioRdata,
  output logic              ioRdValid,
  output logic              cfgUnlocked,
  output logic [7:0]        ldnSel,
  output logic              flashSuspend,
  output logic [2:0]        flashSegEn,
  output logic              flashHostWrEn,
  output logic              flashPinAlt,
  output logic [15:0]       flashIoBase
);

  cfgStrb_t   strb;
  logic [7:0] idxCur;
  logic [7:0] fctlReg;

  cfg_ctrl #(.ADDR_W(ADDR_W), .FLASH_LDN(FLASH_LDN)) uCtrl (
    .clk(clk), .rstN(rstN), .strapAlt(strapAlt),
    .ioWr(ioWr), .ioRd(ioRd), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .ldnCur(ldnSel), .strb(strb), .idxCur(idxCur), .unlocked(cfgUnlocked)
  );

  cfg_data #(.CHIP_ID(CHIP_ID), .CTL_RST(CTL_RST)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(ioWdata), .idxCur(idxCur),
    .ldnReg(ldnSel), .fctlReg(fctlReg), .baseReg(flashIoBase),
    .rdData(ioRdata), .rdValid(ioRdValid)
  );

  assign flashSuspend  = fctlReg[0];
  assign flashSegEn    = fctlReg[3:1];
  assign flashHostWrEn = fctlReg[4];
  assign flashPinAlt   = fctlReg[5];

endmodule

// File: tb/tb_cfg_unlock_top.sv
module tb_cfg_unlock_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapAlt = 1'b0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic [7:0]  ioWdata = 8'h0;
  logic [7:0]  ioRdata;
  logic        ioRdValid;
  logic        cfgUnlocked;
  logic [7:0]  ldnSel;
  logic        flashSuspend;
  logic [2:0]  flashSegEn;
  logic        flashHostWrEn;
  logic        flashPinAlt;
  logic [15:0] flashIoBase;

  localparam logic [7:0] RST_CTL = 8'h06;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic [15:0] pIdx = 16'h2E;
  logic [15:0] pDat = 16'h2F;

  always #4 clk = ~clk;

  cfg_unlock_top #(.CTL_RST(RST_CTL)) dut (
    .clk(clk), .rstN(rstN), .strapAlt(strapAlt), .ioWr(ioWr), .ioRd(ioRd),
    .ioAddr(ioAddr), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioRdValid(ioRdValid),
    .cfgUnlocked(cfgUnlocked), .ldnSel(ldnSel), .flashSuspend(flashSuspend),
    .flashSegEn(flashSegEn), .flashHostWrEn(flashHostWrEn), .flashPinAlt(flashPinAlt),
    .flashIoBase(flashIoBase)
  );

  // monitor: compare read results against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && ioRdValid) begin
      nRun++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R12 unexpected read valid: act=%02h exp=none", ioRdata);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (ioRdata !== e) begin
          nFail++;
          $display("FAIL %s read: act=%02h exp=%02h", t, ioRdata, e);
        end
      end
    end
  end

  task automatic cyc(input bit wr, input bit rd, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWr = wr; ioRd = rd; ioAddr = a; ioWdata = d;
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    expQ.push_back(e); tagQ.push_back(t);
    cyc(1'b0, 1'b1, a, 8'h00);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: act=%0h exp=%0h", t, act, exp);
    end
  endtask

  task automatic doReset(input bit alt);
    @(negedge clk);
    rstN = 1'b0; strapAlt = alt;
    pIdx = alt ? 16'h4E : 16'h2E;
    pDat = alt ? 16'h4F : 16'h2F;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic key(input logic [7:0] last);
    wr(pIdx, 8'h87); wr(pIdx, 8'h01); wr(pIdx, 8'h55); wr(pIdx, last);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired: act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    doReset(1'b0);
    // R1 reset state
    chk(cfgUnlocked, 0, "R1 locked");
    chk(ldnSel, 0, "R1 ldn");
    chk(flashIoBase, 0, "R1 base");
    chk({flashPinAlt, flashHostWrEn, flashSegEn, flashSuspend}, RST_CTL[5:0], "R1 fctl");
    // R5 locked accesses
    rd(pDat, 8'hFF, "R5 data locked");
    rd(pIdx, 8'hFF, "R5 index locked");
    wr(pDat, 8'h3F);
    chk({flashPinAlt, flashHostWrEn, flashSegEn, flashSuspend}, RST_CTL[5:0], "R5 write ignored");
    // R3 wrong final byte for primary strap
    key(8'hAA);
    chk(cfgUnlocked, 0, "R3 wrong final");
    // R4 wrong byte resets matcher
    wr(pIdx, 8'h87); wr(pIdx, 8'h01); wr(pIdx, 8'h13);
    wr(pIdx, 8'h01); wr(pIdx, 8'h55); wr(pIdx, 8'h55);
    chk(cfgUnlocked, 0, "R4 reset to start");
    // R4 0x87 restarts at step two; R2 opens only on last byte
    wr(pIdx, 8'h87); wr(pIdx, 8'h87); wr(pIdx, 8'h01); wr(pIdx, 8'h55);
    chk(cfgUnlocked, 0, "R2 not before last");
    wr(pIdx, 8'h55);
    chk(cfgUnlocked, 1, "R4 R2 unlocked");
    // R6 / R8
    wr(pIdx, 8'h20);
    rd(pIdx, 8'h20, "R6 index readback");
    rd(pDat, 8'h87, "R8 id high");
    wr(pIdx, 8'h21);
    wr(pDat, 8'h99);
    rd(pDat, 8'h16, "R8 id low read-only");
    // R10 flash control
    wr(pIdx, 8'h24); wr(pDat, 8'h3B);
    chk({flashPinAlt, flashHostWrEn, flashSegEn, flashSuspend}, 6'h3B, "R10 fields");
    chk(flashSegEn, 3'b101, "R10 segments");
    rd(pDat, 8'h3B, "R10 readback");
    // R9 bank gating
    wr(pIdx, 8'h07); wr(pDat, 8'h03);
    chk(ldnSel, 8'h03, "R9 ldn");
    wr(pIdx, 8'h64); wr(pDat, 8'hAB);
    chk(flashIoBase, 16'h0000, "R9 write outside bank");
    rd(pDat, 8'hFF, "R9 read outside bank");
    wr(pIdx, 8'h07); wr(pDat, 8'h07);
    wr(pIdx, 8'h64); wr(pDat, 8'h0A);
    wr(pIdx, 8'h65); wr(pDat, 8'h20);
    chk(flashIoBase, 16'h0A20, "R9 base");
    rd(pDat, 8'h20, "R9 low readback");
    wr(pIdx, 8'h64);
    rd(pDat, 8'h0A, "R9 high readback");
    wr(pIdx, 8'h07);
    rd(pDat, 8'h07, "R9 ldn readback");
    wr(pDat, 8'h03);
    wr(pIdx, 8'h24);
    rd(pDat, 8'h3B, "R10 global under other ldn");
    // R11 simultaneous write and read
    expQ.push_back(8'h3B); tagQ.push_back("R11 read sees old value");
    cyc(1'b1, 1'b1, pDat, 8'h11);
    rd(pDat, 8'h11, "R11 new value after");
    // R12 foreign address
    cyc(1'b0, 1'b1, 16'h0030, 8'h00);
    wr(16'h0030, 8'h3F);
    wr(16'h004F, 8'h3F);
    chk({flashPinAlt, flashHostWrEn, flashSegEn, flashSuspend}, 6'h11, "R12 foreign write");
    // R7 relock
    wr(pIdx, 8'h02); wr(pDat, 8'h01);
    chk(cfgUnlocked, 1, "R7 other value");
    wr(pDat, 8'h02);
    chk(cfgUnlocked, 0, "R7 relocked");
    rd(pDat, 8'hFF, "R7 R5 data after relock");
    // R3 alternate strap
    doReset(1'b1);
    chk(cfgUnlocked, 0, "R1 locked alt");
    key(8'h55);
    chk(cfgUnlocked, 0, "R3 alt needs AA");
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    chk(cfgUnlocked, 0, "R3 primary pair ignored");
    key(8'hAA);
    chk(cfgUnlocked, 1, "R3 alt unlocked");
    wr(pIdx, 8'h20);
    rd(pDat, 8'h87, "R3 alt data port");
    repeat (3) @(negedge clk);
    chk(expQ.size(), 0, "R11 all reads returned");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule